// File: doc/BRIEF.md
# Serial Byte Wait and Interrupt Controller

This block sits next to a shift-register serial engine that runs either as a plain clocked serial port or as a two-wire I2C-style interface. It counts rising edges of the serial clock during a byte and, on the 8th or 9th edge, raises an end-of-byte interrupt. In the two I2C modes it then pulls the clock line low to hold the bus in a wait state. The wait lasts until software writes a release bit, which clears itself one cycle later.

An 8-bit control register sets the wait mode, the idle level of the clock line, the slave-address compare mask and whether a stop condition also raises the interrupt. A read-only bit in the same register shows the live clock-pin level. The interrupt is given as a one-cycle pulse and as a sticky flag that software clears with a write-one-to-clear strobe. Start/stop generation, the data shifter and the address comparator belong to neighbouring blocks.

Top module: `serial_wait_ctrl`

## Requirements
- R1: After reset the register reads 0x00 while the interface is disabled, `irq_pulse_o`, `irq_flag_o` and `scl_pull_low_o` are 0, and `addr_mask_o` is all ones.
- R2: The register layout is: [1:0] wait mode, [2] release, [3] idle-clock release (clock level), [4] address-mask select, [5] stop-interrupt enable, [6] clock-pin level, [7] constant 0. A write updates bits 0 to 5. Bits 6 and 7 of the written data are ignored.
- R3: Bit 6 reads `scl_pin_i` while `sif_en_i` is 1, and reads 0 while `sif_en_i` is 0.
- R4: In mode 00, and in the reserved mode 01, `irq_pulse_o` is 1 for the cycle after the clock edge on which the 8th `scl_rise_i` is sampled. `scl_pull_low_o` stays 0 in both modes.
- R5: In mode 10 the interrupt comes on the 8th edge, as in R4. From the same edge on, a wait state holds `scl_pull_low_o` at 1.
- R6: In mode 11 the 8th edge raises no interrupt. The interrupt and the wait state come on the 9th edge.
- R7: Writing a 1 to bit 2 makes bit 2 read 1 for exactly one cycle. That cycle ends the wait state and restarts the edge count from 0, and bit 2 then reads 0.
- R8: Clock edges that arrive during a wait state are not counted and raise no interrupt.
- R9: `start_det_i` resets the edge count to 0. An edge sampled in the same cycle as the start is not counted.
- R10: In modes 10 and 11, with no wait state and `xfer_active_i` at 0, `scl_pull_low_o` equals the inverse of bit 3.
- R11: `addr_mask_o` is all ones when bit 4 is 0. When bit 4 is 1, its bit 0 is 0 and all other bits are 1.
- R12: With bit 5 at 1, a sampled `stop_det_i` raises `irq_pulse_o` in the next cycle. With bit 5 at 0 it raises nothing. A stop and an 8th edge in the same cycle give one single-cycle pulse.
- R13: `irq_flag_o` goes to 1 with every pulse and stays 1 until `irq_clr_i` is sampled. If a pulse and a clear arrive in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sif_en_i | input | 1 | Serial interface enable |
| xfer_active_i | input | 1 | A byte transfer is in progress |
| scl_rise_i | input | 1 | One-cycle pulse on each serial clock rising edge |
| scl_pin_i | input | 1 | Synchronised clock-pin level |
| start_det_i | input | 1 | Start condition detected (pulse) |
| stop_det_i | input | 1 | Stop condition detected (pulse) |
| irq_clr_i | input | 1 | Clear strobe for the sticky interrupt flag |
| scl_pull_low_o | output | 1 | Enables the clock-line pull-down |
| irq_pulse_o | output | 1 | One-cycle interrupt pulse |
| irq_flag_o | output | 1 | Sticky interrupt flag |
| addr_mask_o | output | ADDR_W | Slave-address compare mask |

## Verification
Several pairs of events can land in the same cycle. A stop with the stop interrupt enabled can coincide with the final counted edge, and a clear strobe can coincide with a new interrupt. A start can coincide with a clock edge, and edges keep arriving while a wait is in force. The bench drives each pair into a single cycle. It expects exactly one pulse and a flag that stays 1, a start that discards its edge so the next byte still needs its full count, and edges during a wait that have no effect. A behavioural model compares every output on every clock.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;
  typedef enum logic [1:0] {
    WM_PLAIN = 2'b00,
    WM_RSVD  = 2'b01,
    WM_I2C8  = 2'b10,
    WM_I2C9  = 2'b11
  } wait_mode_e;

  localparam int unsigned B_REL  = 2;
  localparam int unsigned B_CLC  = 3;
  localparam int unsigned B_AMSK = 4;
  localparam int unsigned B_SIC  = 5;
  localparam int unsigned B_LVL  = 6;

  typedef struct packed {
    logic       sic;
    logic       amsk;
    logic       clc;
    wait_mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/swc_ctrl_reg.sv
`timescale 1ns/1ps
module swc_ctrl_reg
  import swc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [5:0] wdata_i,
  input  logic       sif_en_i,
  input  logic       scl_pin_i,
  output ctrl_t      ctrl_o,
  output logic       rel_o,
  output logic [7:0] rdata_o
);
  ctrl_t ctrl_q;
  logic  rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rel_q  <= 1'b0;
    end else begin
      // release bit lives for one cycle only
      rel_q <= wr_i & wdata_i[B_REL];
      if (wr_i) begin
        ctrl_q.mode <= wait_mode_e'(wdata_i[1:0]);
        ctrl_q.clc  <= wdata_i[B_CLC];
        ctrl_q.amsk <= wdata_i[B_AMSK];
        ctrl_q.sic  <= wdata_i[B_SIC];
      end
    end
  end

  always_comb begin
    rdata_o         = '0;
    rdata_o[1:0]    = ctrl_q.mode;
    rdata_o[B_REL]  = rel_q;
    rdata_o[B_CLC]  = ctrl_q.clc;
    rdata_o[B_AMSK] = ctrl_q.amsk;
    rdata_o[B_SIC]  = ctrl_q.sic;
    rdata_o[B_LVL]  = sif_en_i & scl_pin_i;
  end

  assign ctrl_o = ctrl_q;
  assign rel_o  = rel_q;
endmodule

// File: rtl/swc_edge_count.sv
`timescale 1ns/1ps
module swc_edge_count
  import swc_pkg::*;
#(
  parameter int unsigned SHORT_LEN = 8,
  parameter int unsigned LONG_LEN  = 9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       rel_i,
  input  logic       rise_i,
  input  wait_mode_e mode_i,
  output logic       hit_o,
  output logic       wait_o
);
  localparam int unsigned CNT_W = $clog2(LONG_LEN + 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_LEN - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wait_q;
  logic             last;
  logic             count_ok;

  assign last     = (cnt_q == ((mode_i == WM_I2C9) ? LONG_LAST : SHORT_LAST));
  assign count_ok = en_i & ~rel_i & ~start_i & rise_i & ~wait_q;
  assign hit_o    = count_ok & last;
  assign wait_o   = wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else if (rel_i) begin
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= '0;
    end else if (count_ok) begin
      if (last) begin
        cnt_q  <= '0;
        wait_q <= mode_i[1];
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swc_irq.sv
`timescale 1ns/1ps
module swc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic stop_i,
  input  logic sic_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic flag_o
);
  logic set;
  logic pulse_q, flag_q;

  assign set = hit_i | (stop_i & sic_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= set;
      flag_q  <= set | (flag_q & ~clr_i);  // set beats clear
    end
  end

  assign pulse_o = pulse_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/serial_wait_ctrl.sv
`timescale 1ns/1ps
module serial_wait_ctrl
  import swc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SHORT_LEN = 8,
  parameter int unsigned LONG_LEN  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              sif_en_i,
  input  logic              xfer_active_i,
  input  logic              scl_rise_i,
  input  logic              scl_pin_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              irq_clr_i,
  output logic              scl_pull_low_o,
  output logic              irq_pulse_o,
  output logic              irq_flag_o,
  output logic [ADDR_W-1:0] addr_mask_o
);
  ctrl_t ctrl;
  logic  rel_act, wait_act, hit;
  logic  unused_wbits;

  assign unused_wbits = ^reg_wdata_i[7:6];

  swc_ctrl_reg u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i[5:0]),
    .sif_en_i (sif_en_i),
    .scl_pin_i(scl_pin_i),
    .ctrl_o   (ctrl),
    .rel_o    (rel_act),
    .rdata_o  (reg_rdata_o)
  );

  swc_edge_count #(
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (sif_en_i),
    .start_i(start_det_i),
    .rel_i  (rel_act),
    .rise_i (scl_rise_i),
    .mode_i (ctrl.mode),
    .hit_o  (hit),
    .wait_o (wait_act)
  );

  swc_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .stop_i (stop_det_i),
    .sic_i  (ctrl.sic),
    .clr_i  (irq_clr_i),
    .pulse_o(irq_pulse_o),
    .flag_o (irq_flag_o)
  );

  // pull-down only in two-wire modes: during a wait, or idle with low level chosen
  assign scl_pull_low_o = sif_en_i & ctrl.mode[1] &
                          (wait_act | (~ctrl.clc & ~xfer_active_i));

  generate
    if (ADDR_W > 1) begin : g_mask_wide
      assign addr_mask_o = {{(ADDR_W-1){1'b1}}, ~ctrl.amsk};
    end else begin : g_mask_one
      assign addr_mask_o = ~ctrl.amsk;
    end
  endgenerate
endmodule

// File: rtl/swc_checker.sv
`timescale 1ns/1ps
module swc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       sif_en_i,
  input logic       scl_rise_i,
  input logic       start_det_i,
  input logic       stop_det_i,
  input logic       irq_clr_i,
  input logic       scl_pull_low_o,
  input logic       irq_pulse_o,
  input logic       irq_flag_o,
  input logic       mask0_i,
  input logic       wait_i,
  input logic       rel_i
);
  assert_level_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sif_en_i |-> !reg_rdata_o[6]);

  assert_plain_no_pull_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[1] |-> !scl_pull_low_o);

  assert_wait_pulls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && reg_rdata_o[1] && sif_en_i) |-> scl_pull_low_o);

  assert_wait_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !rel_i && sif_en_i) |=> wait_i);

  assert_release_selfclear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[2] && !(reg_wr_i && reg_wdata_i[2])) |=> !reg_rdata_o[2]);

  assert_release_ends_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> !wait_i);

  assert_wait_ignores_edges_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !rel_i && scl_rise_i && !stop_det_i) |=> !irq_pulse_o);

  assert_start_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_det_i && !stop_det_i) |=> !irq_pulse_o);

  assert_mask_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask0_i == !reg_rdata_o[4]);

  assert_stop_off_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det_i && !reg_rdata_o[5] && !scl_rise_i) |=> !irq_pulse_o);

  assert_pulse_flag_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pulse_o |-> irq_flag_o);

  assert_flag_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && !irq_clr_i) |=> irq_flag_o);

  assert_flag_clear_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_o && irq_clr_i) |=> (!irq_flag_o || irq_pulse_o));
endmodule

bind serial_wait_ctrl swc_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_wr_i      (reg_wr_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .sif_en_i      (sif_en_i),
  .scl_rise_i    (scl_rise_i),
  .start_det_i   (start_det_i),
  .stop_det_i    (stop_det_i),
  .irq_clr_i     (irq_clr_i),
  .scl_pull_low_o(scl_pull_low_o),
  .irq_pulse_o   (irq_pulse_o),
  .irq_flag_o    (irq_flag_o),
  .mask0_i       (addr_mask_o[0]),
  .wait_i        (wait_act),
  .rel_i         (rel_act)
);

// File: tb/serial_wait_ctrl_bench.sv
`timescale 1ns/1ps
module serial_wait_ctrl_bench;
  localparam real CLK_NS = 4.0;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr = 0, en = 0, xfer = 0, rise = 0, pin = 0, start = 0, stop = 0, clr = 0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, mask;
  logic       pull, pulse, flag;

  int checks = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_mode = 0;
  bit m_wait = 0, m_rel = 0, m_clc = 0, m_amsk = 0, m_sic = 0, m_pulse = 0, m_flag = 0;

  always #(CLK_NS/2) clk = ~clk;

  serial_wait_ctrl u_serial_wait_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .sif_en_i(en), .xfer_active_i(xfer), .scl_rise_i(rise), .scl_pin_i(pin),
    .start_det_i(start), .stop_det_i(stop), .irq_clr_i(clr),
    .scl_pull_low_o(pull), .irq_pulse_o(pulse), .irq_flag_o(flag), .addr_mask_o(mask)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      bit hit;
      int tgt;
      hit = 0;
      tgt = (m_mode == 3) ? 9 : 8;
      if (!en) begin m_cnt = 0; m_wait = 0; end
      else if (m_rel) begin m_cnt = 0; m_wait = 0; end
      else if (start) m_cnt = 0;
      else if (rise && !m_wait) begin
        if (m_cnt + 1 == tgt) begin
          hit = 1; m_cnt = 0;
          if (m_mode >= 2) m_wait = 1;
        end else m_cnt++;
      end
      m_pulse = hit || (stop && m_sic);
      m_flag  = m_pulse ? 1'b1 : (clr ? 1'b0 : m_flag);
      m_rel   = wr && wd[2];
      if (wr) begin
        m_mode = int'(wd[1:0]); m_clc = wd[3]; m_amsk = wd[4]; m_sic = wd[5];
      end
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] exp_rd;
      logic       exp_pull;
      exp_rd   = {1'b0, en & pin, m_sic, m_amsk, m_clc, m_rel, 2'(m_mode)};
      exp_pull = en && (m_mode >= 2) && (m_wait || (!m_clc && !xfer));
      chk("R2 model rdata", rdata, exp_rd);
      chk("R5 model pull", {7'd0, pull}, {7'd0, exp_pull});
      chk("R4 model pulse", {7'd0, pulse}, {7'd0, m_pulse});
      chk("R13 model flag", {7'd0, flag}, {7'd0, m_flag});
      chk("R11 model mask", mask, m_amsk ? 8'hFE : 8'hFF);
    end
  end

  task automatic drive(input logic r, s, p, c, w, input logic [7:0] d);
    @(negedge clk);
    rise = r; start = s; stop = p; clr = c; wr = w; wd = d;
    @(negedge clk);
    rise = 0; start = 0; stop = 0; clr = 0; wr = 0;
  endtask

  task automatic wreg(input logic [7:0] d); drive(0, 0, 0, 0, 1, d); endtask

  task automatic rises(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 outputs", {5'd0, pulse, flag, pull}, 8'h00);
    chk("R1 mask", mask, 8'hFF);

    // R2 layout, bits 7..6 of write ignored
    wreg(8'hF0);
    chk("R2 readback", rdata, 8'h30);
    wreg(8'h00);

    // R3 pin level gating
    @(negedge clk); en = 1; pin = 1; @(negedge clk);
    chk("R3 level high", rdata, 8'h40);
    pin = 0; @(negedge clk);
    chk("R3 level low", rdata, 8'h00);
    en = 0; pin = 1; @(negedge clk);
    chk("R3 disabled", rdata, 8'h00);
    pin = 0; en = 1;

    // R4 plain mode and reserved mode
    rises(7);
    chk("R4 no pulse at 7", {7'd0, pulse}, 8'h00);
    rises(1);
    chk("R4 pulse at 8", {7'd0, pulse}, 8'h01);
    chk("R4 no pull", {7'd0, pull}, 8'h00);
    wreg(8'h01);
    rises(8);
    chk("R4 reserved mode pulse", {7'd0, pulse}, 8'h01);
    chk("R4 reserved no pull", {7'd0, pull}, 8'h00);

    // R10 idle clock level
    wreg(8'h02);
    chk("R10 idle low", {7'd0, pull}, 8'h01);
    wreg(8'h0A);
    chk("R10 idle released", {7'd0, pull}, 8'h00);

    // R5 eight-clock wait
    xfer = 1;
    wreg(8'h02);
    chk("R5 no pull in transfer", {7'd0, pull}, 8'h00);
    rises(8);
    chk("R5 pulse at 8", {7'd0, pulse}, 8'h01);
    chk("R5 wait pull", {7'd0, pull}, 8'h01);

    // R8 edges during wait
    rises(3);
    chk("R8 no pulse in wait", {7'd0, pulse}, 8'h00);
    chk("R8 still held", {7'd0, pull}, 8'h01);

    // R7 self-clearing release
    wreg(8'h06);
    chk("R7 release reads 1", rdata, 8'h06);
    @(negedge clk);
    chk("R7 release cleared", rdata, 8'h02);
    chk("R7 wait ended", {7'd0, pull}, 8'h00);
    rises(7);
    chk("R7 count restarted", {7'd0, pulse}, 8'h00);
    rises(1);
    chk("R7 next byte pulse", {7'd0, pulse}, 8'h01);

    // R6 nine-clock wait
    wreg(8'h07);
    rises(8);
    chk("R6 no pulse at 8", {7'd0, pulse}, 8'h00);
    chk("R6 no hold at 8", {7'd0, pull}, 8'h00);
    rises(1);
    chk("R6 pulse at 9", {7'd0, pulse}, 8'h01);
    chk("R6 hold at 9", {7'd0, pull}, 8'h01);
    wreg(8'h04);

    // R9 start with coincident edge
    rises(3);
    drive(1, 1, 0, 0, 0, 8'h00);
    chk("R9 start no pulse", {7'd0, pulse}, 8'h00);
    rises(7);
    chk("R9 edge dropped", {7'd0, pulse}, 8'h00);
    rises(1);
    chk("R9 pulse after full byte", {7'd0, pulse}, 8'h01);

    // R11 address mask
    wreg(8'h10);
    chk("R11 mask bit0 ignored", mask, 8'hFE);
    wreg(8'h00);
    chk("R11 mask full", mask, 8'hFF);

    // R12 stop interrupt
    drive(0, 0, 1, 0, 0, 8'h00);
    chk("R12 stop ignored", {7'd0, pulse}, 8'h00);
    wreg(8'h20);
    drive(0, 0, 1, 0, 0, 8'h00);
    chk("R12 stop pulse", {7'd0, pulse}, 8'h01);
    rises(7);
    drive(1, 0, 1, 0, 0, 8'h00);
    chk("R12 merged pulse", {7'd0, pulse}, 8'h01);
    @(negedge clk);
    chk("R12 single cycle", {7'd0, pulse}, 8'h00);

    // R13 sticky flag
    chk("R13 flag set", {7'd0, flag}, 8'h01);
    drive(0, 0, 0, 1, 0, 8'h00);
    chk("R13 flag cleared", {7'd0, flag}, 8'h00);
    drive(0, 0, 1, 1, 0, 8'h00);
    chk("R13 set wins", {7'd0, flag}, 8'h01);
    drive(0, 0, 0, 1, 0, 8'h00);
    chk("R13 cleared again", {7'd0, flag}, 8'h00);

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule